// File: doc/BRIEF.md
# PLL Programming and Lock Sequencer

This block brings a clock-synthesis PLL controller from a fresh divider setting to running outputs. Its only link to the controller is a 32-bit register port: a one-cycle write strobe, and a one-cycle read strobe whose data comes back with a valid flag on the next cycle. When `start` is pulsed, the sequencer captures the reference divider, the feedback multiplier, four output dividers and the internal reference frequency. It writes three configuration words, with the outputs held in bypass. It then fires the self-clearing GO bit and waits for the PLL to lock. Once lock is seen, it releases bypass and enables the outputs whose divider is nonzero. Last, it waits for the matching acknowledge bits in the status word.

There are two lock strategies. In normal mode, the sequencer polls the GO bit until it clears, then polls the lock bit. In retry mode, each attempt fires GO and waits a fixed settle time. It then checks a masked multi-bit status pattern and the GO bit, and retries a bounded number of times. All waits have cycle-count limits. A failure stops all register traffic. The sequencer then finishes with `done` and `error` raised together and a code that names the wait that failed.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0, `err_code` is 0, and no register write is issued until `start`.
- R2: The word written to address 2 carries N-1 in bits 7:0, M in bits 19:8, output divider 0 minus 1 in bits 24:20 and output divider 1 minus 1 in bits 29:25. A divider of 0 is written as 0.
- R3: The word written to address 4 carries output divider 2 minus 1 in bits 4:0 and output divider 3 minus 1 in bits 9:5. A divider of 0 is written as 0. All other bits are 0.
- R4: Before the GO write, the writes go in the order address 2, 4, 3. The address-3 word has bit 13 (reference enable) and bit 20 (output bypass) set, bits 22:21 equal to 3, and bits 14, 16, 18, 23 and 25 clear.
- R5: Bits 4:1 of both address-3 words give the band: 3, 4, 5 or 6 when the reference (`fint_khz`) is below 1000, 1250, 1500 or 1750 kHz respectively, and 7 otherwise.
- R6: In normal mode, exactly one GO write (value 1 at address 0) is made. The sequencer waits for address-0 bit 0 to read 0 and then for status (address 1) bit 1 to read 1. Failing the first wait gives code 1 and failing the second gives code 2.
- R7: Each wait polls back to back for FAST_POLLS reads, then once every GAP_CYC cycles. It gives up only when LONG_TMO cycles have passed since the wait began. A lock that arrives after the fast phase still succeeds.
- R8: In retry mode, each attempt writes GO, waits SETTLE_CYC cycles, and reads status, then GO. The attempt succeeds only if (status AND 0x6F) equals 0x03 and GO bit 0 reads 0, so status bits 4 and 7 have no effect on it. After RETRIES failed attempts, code 2 is reported.
- R9: Only after lock, a second address-3 word sets bit 14, clears bit 20, and sets enable bits 16, 18, 23 and 25 for outputs 0 to 3 exactly when that output's divider is nonzero. On a lock failure this word is never written.
- R10: After release, status ack bits 7, 8, 10 and 11 (outputs 0 to 3) must all be set for every enabled output within ACK_POLLS reads, or code 3 is reported.
- R11: `done` is a one-cycle pulse. `error` is raised in the same cycle exactly when a wait failed. `err_code` holds until the next `start`. No register write follows a finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (accepted when idle) |
| retry_mode | input | 1 | 1 selects the bounded GO-retry lock strategy |
| div_n | input | 8 | Reference divider N (1 or more) |
| div_m | input | 12 | Feedback multiplier M |
| div_x | input | 4x5 | Output dividers 0 to 3, 0 means unused |
| fint_khz | input | 16 | Internal reference frequency in kHz |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 3 | Word address (0 GO, 1 status, 2/3/4 configuration) |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid one cycle after `reg_rd` |
| reg_rvalid | input | 1 | Read data valid |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle finish pulse |
| error | output | 1 | Run failed, valid with `done` |
| err_code | output | 2 | 0 none, 1 GO stuck, 2 no lock, 3 no ack |

## Verification
A wrong state in the sequencer shows at the register port within a few cycles. It appears as a configuration word with a field in the wrong place, as the words arriving out of order, or as the release word arriving before a successful lock read. A fault in the timeout counting shows later, but at a bounded time. The finish then comes too early, or after the long limit, or the retry mode makes a GO write count other than the one its status pattern allows. The bench checks the written words against values it builds from the field rules. It also measures the time from start to finish, and counts GO writes and late writes.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int NW   = 8;
    localparam int MW   = 12;
    localparam int XW   = 5;
    localparam int NOUT = 4;
    localparam int FW   = 16;

    localparam logic [2:0] A_GO   = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_CFG1 = 3'd2;
    localparam logic [2:0] A_CFG2 = 3'd3;
    localparam logic [2:0] A_CFG3 = 3'd4;

    localparam int B_REFEN = 13;
    localparam int B_PHYEN = 14;
    localparam int B_BYP   = 20;
    localparam int EN_BIT  [NOUT] = '{16, 18, 23, 25};
    localparam int ACK_BIT [NOUT] = '{7, 8, 10, 11};

    localparam logic [31:0] LOCK_MASK = 32'h0000_006F;
    localparam logic [31:0] LOCK_WANT = 32'h0000_0003;

    typedef enum logic [3:0] {
        S_IDLE, S_WR1, S_WR3, S_WR2A, S_WRGO, S_PRD, S_PCHK, S_PGAP,
        S_SETTLE, S_WRST, S_WCKST, S_WRGR, S_WCKGR, S_WR2B, S_FIN
    } st_e;

    typedef enum logic [1:0] {PH_GO, PH_LOCK, PH_ACK} ph_e;

    typedef enum logic [1:0] {E_NONE = 2'd0, E_GO = 2'd1, E_LOCK = 2'd2, E_ACK = 2'd3} err_e;
endpackage

// File: rtl/pll_seq_words.sv
module pll_seq_words
    import pll_seq_pkg::*;
(
    input  logic [NW-1:0]            n,
    input  logic [MW-1:0]            m,
    input  logic [NOUT-1:0][XW-1:0]  d,
    input  logic [FW-1:0]            fint_khz,
    output logic [31:0]              cfg1,
    output logic [31:0]              cfg3,
    output logic [31:0]              cfg2_pre,
    output logic [31:0]              cfg2_post,
    output logic [31:0]              ack_mask
);
    logic [NOUT-1:0][XW-1:0] dm;
    logic [NOUT-1:0]         used;
    logic [3:0]              band;

    for (genvar i = 0; i < NOUT; i++) begin : g_div
        assign used[i] = |d[i];
        assign dm[i]   = used[i] ? d[i] - 1'b1 : '0;
    end

    always_comb begin
        if      (fint_khz < FW'(1000)) band = 4'd3;
        else if (fint_khz < FW'(1250)) band = 4'd4;
        else if (fint_khz < FW'(1500)) band = 4'd5;
        else if (fint_khz < FW'(1750)) band = 4'd6;
        else                           band = 4'd7;
    end

    always_comb begin
        cfg1 = '0;
        cfg3 = '0;
        cfg1[NW-1:0]  = n - 1'b1;
        cfg1[NW +: MW] = m;
        for (int i = 0; i < NOUT; i++) begin
            if (i < 2) cfg1[NW + MW + i*XW +: XW] = dm[i];
            else       cfg3[(i-2)*XW +: XW]       = dm[i];
        end

        cfg2_pre          = '0;
        cfg2_pre[4:1]     = band;
        cfg2_pre[B_REFEN] = 1'b1;
        cfg2_pre[22:21]   = 2'd3;
        cfg2_post         = cfg2_pre;
        cfg2_pre[B_BYP]   = 1'b1;
        cfg2_post[B_PHYEN] = 1'b1;

        ack_mask = '0;
        for (int i = 0; i < NOUT; i++) begin
            cfg2_post[EN_BIT[i]] = used[i];
            ack_mask[ACK_BIT[i]] = used[i];
        end
    end
endmodule

// File: rtl/pll_seq_pace.sv
module pll_seq_pace #(
    parameter int CW         = 12,
    parameter int FAST_POLLS = 100,
    parameter int GAP_CYC    = 16,
    parameter int LONG_TMO   = 2000,
    parameter int PW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          miss,
    output logic          issue_ok,
    output logic          expired,
    output logic [PW-1:0] polls,
    output logic [CW-1:0] cyc
);
    localparam int GW = $clog2(GAP_CYC + 1) + 1;

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [PW-1:0] polls;
        logic [GW-1:0] gap;
    } pace_t;

    pace_t q, d;

    always_comb begin
        d = q;
        if (q.cyc != '1) d.cyc = q.cyc + 1'b1;
        if (q.gap != '1) d.gap = q.gap + 1'b1;
        if (miss) begin
            d.gap = '0;
            if (q.polls != '1) d.polls = q.polls + 1'b1;
        end
        if (clr) d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign issue_ok = (q.polls < PW'(FAST_POLLS)) || (q.gap >= GW'(GAP_CYC));
    assign expired  = q.cyc >= CW'(LONG_TMO);
    assign polls    = q.polls;
    assign cyc      = q.cyc;

    a_r7_gap_after_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !clr && q.polls >= PW'(FAST_POLLS)) |=> !issue_ok);
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
    import pll_seq_pkg::*;
#(
    parameter int LONG_TMO   = 2000,
    parameter int FAST_POLLS = 100,
    parameter int GAP_CYC    = 16,
    parameter int ACK_POLLS  = 100,
    parameter int SETTLE_CYC = 1000,
    parameter int RETRIES    = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    retry_mode,
    input  logic [7:0]              div_n,
    input  logic [11:0]             div_m,
    input  logic [3:0][4:0]         div_x,
    input  logic [15:0]             fint_khz,
    output logic                    reg_wr,
    output logic                    reg_rd,
    output logic [2:0]              reg_addr,
    output logic [31:0]             reg_wdata,
    input  logic [31:0]             reg_rdata,
    input  logic                    reg_rvalid,
    output logic                    busy,
    output logic                    done,
    output logic                    error,
    output logic [1:0]              err_code
);
    localparam int TMAX = (LONG_TMO > SETTLE_CYC) ? LONG_TMO : SETTLE_CYC;
    localparam int CW   = $clog2(TMAX + 1) + 1;
    localparam int PMAX = (FAST_POLLS > ACK_POLLS) ? FAST_POLLS : ACK_POLLS;
    localparam int PW   = $clog2(PMAX + 1) + 1;
    localparam int RW   = $clog2(RETRIES + 1);

    typedef struct packed {
        st_e                   st;
        ph_e                   ph;
        logic                  wa;
        logic [NW-1:0]         n;
        logic [MW-1:0]         m;
        logic [NOUT-1:0][XW-1:0] d;
        logic [FW-1:0]         fint;
        logic [RW-1:0]         rt;
        err_e                  code;
    } seq_t;

    seq_t q, nx;
    logic clr, miss, issue_ok, expired;
    logic [PW-1:0] polls;
    logic [CW-1:0] cyc;
    logic [31:0] cfg1, cfg3, cfg2_pre, cfg2_post, ack_mask;
    logic hit;

    pll_seq_words u_words (
        .n(q.n), .m(q.m), .d(q.d), .fint_khz(q.fint),
        .cfg1(cfg1), .cfg3(cfg3), .cfg2_pre(cfg2_pre),
        .cfg2_post(cfg2_post), .ack_mask(ack_mask)
    );

    pll_seq_pace #(
        .CW(CW), .FAST_POLLS(FAST_POLLS), .GAP_CYC(GAP_CYC),
        .LONG_TMO(LONG_TMO), .PW(PW)
    ) u_pace (
        .clk(clk), .rst_n(rst_n), .clr(clr), .miss(miss),
        .issue_ok(issue_ok), .expired(expired), .polls(polls), .cyc(cyc)
    );

    always_comb begin
        case (q.ph)
            PH_GO:   hit = !reg_rdata[0];
            PH_LOCK: hit = reg_rdata[1];
            default: hit = (reg_rdata & ack_mask) == ack_mask;
        endcase
    end

    always_comb begin
        nx   = q;
        clr  = 1'b0;
        miss = 1'b0;
        case (q.st)
            S_IDLE: if (start) begin
                nx.n    = div_n;
                nx.m    = div_m;
                nx.d    = div_x;
                nx.fint = fint_khz;
                nx.wa   = retry_mode;
                nx.rt   = '0;
                nx.code = E_NONE;
                nx.st   = S_WR1;
            end
            S_WR1:  nx.st = S_WR3;
            S_WR3:  nx.st = S_WR2A;
            S_WR2A: nx.st = S_WRGO;
            S_WRGO: begin
                clr   = 1'b1;
                nx.ph = PH_GO;
                nx.st = q.wa ? S_SETTLE : S_PRD;
            end
            S_PRD: nx.st = S_PCHK;
            S_PCHK: if (reg_rvalid) begin
                if (hit) begin
                    case (q.ph)
                        PH_GO:   begin nx.ph = PH_LOCK; clr = 1'b1; nx.st = S_PRD; end
                        PH_LOCK: nx.st = S_WR2B;
                        default: nx.st = S_FIN;
                    endcase
                end else if (q.ph == PH_ACK ? (polls >= PW'(ACK_POLLS - 1)) : expired) begin
                    nx.code = (q.ph == PH_GO) ? E_GO : (q.ph == PH_LOCK) ? E_LOCK : E_ACK;
                    nx.st   = S_FIN;
                end else begin
                    miss  = 1'b1;
                    nx.st = S_PGAP;
                end
            end
            S_PGAP:   if (issue_ok) nx.st = S_PRD;
            S_SETTLE: if (cyc >= CW'(SETTLE_CYC - 1)) nx.st = S_WRST;
            S_WRST:   nx.st = S_WCKST;
            S_WCKST, S_WCKGR: if (reg_rvalid) begin
                if (q.st == S_WCKST && (reg_rdata & LOCK_MASK) == LOCK_WANT)
                    nx.st = S_WRGR;
                else if (q.st == S_WCKGR && !reg_rdata[0])
                    nx.st = S_WR2B;
                else if (q.rt == RW'(RETRIES - 1)) begin
                    nx.code = E_LOCK;
                    nx.st   = S_FIN;
                end else begin
                    nx.rt = q.rt + 1'b1;
                    nx.st = S_WRGO;
                end
            end
            S_WRGR: nx.st = S_WCKGR;
            S_WR2B: begin
                clr   = 1'b1;
                nx.ph = PH_ACK;
                nx.st = S_PRD;
            end
            default: nx.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.code <= E_NONE;
        end else begin
            q <= nx;
        end
    end

    always_comb begin
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = A_GO;
        reg_wdata = '0;
        case (q.st)
            S_WR1:  begin reg_wr = 1'b1; reg_addr = A_CFG1; reg_wdata = cfg1; end
            S_WR3:  begin reg_wr = 1'b1; reg_addr = A_CFG3; reg_wdata = cfg3; end
            S_WR2A: begin reg_wr = 1'b1; reg_addr = A_CFG2; reg_wdata = cfg2_pre; end
            S_WRGO: begin reg_wr = 1'b1; reg_addr = A_GO;   reg_wdata = 32'd1; end
            S_WR2B: begin reg_wr = 1'b1; reg_addr = A_CFG2; reg_wdata = cfg2_post; end
            S_PRD:  begin reg_rd = 1'b1; reg_addr = (q.ph == PH_GO) ? A_GO : A_STAT; end
            S_WRST: begin reg_rd = 1'b1; reg_addr = A_STAT; end
            S_WRGR: begin reg_rd = 1'b1; reg_addr = A_GO; end
            default: ;
        endcase
    end

    assign busy     = q.st != S_IDLE;
    assign done     = q.st == S_FIN;
    assign error    = done && (q.code != E_NONE);
    assign err_code = q.code;

    a_r11_error_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!reg_wr && !done));
    a_r9_release_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CFG2 && !reg_wdata[B_BYP]) |-> $past(reg_rvalid));
    a_r8_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.rt < RW'(RETRIES));
    a_r6_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd));
endmodule

// File: tb/pll_lock_seq_tb.sv
`timescale 1ns/1ps
module pll_lock_seq_tb;
    localparam int LONG_TMO = 2000;
    localparam int SETTLE   = 1000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, start, retry_mode;
    logic [7:0] div_n;
    logic [11:0] div_m;
    logic [3:0][4:0] div_x;
    logic [15:0] fint_khz;
    logic reg_wr, reg_rd, reg_rvalid, busy, done, error;
    logic [2:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [1:0] err_code;

    pll_lock_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .retry_mode(retry_mode),
        .div_n(div_n), .div_m(div_m), .div_x(div_x), .fint_khz(fint_khz),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    // PLL controller model and its knobs
    int go_delay, lock_delay, ack_delay, jit_until;
    logic go_stuck, no_lock, ack_stuck, bit4_on, clr_stats;
    logic go_bit, locked, armed;
    logic [3:0] acks;
    int go_cnt, lk_cnt, ack_cnt, go_writes, cfg2_n, late_wr;
    logic [31:0] cfg1_w, cfg2_w, cfg3_w, cfg2_first, cfg2_second, status;
    logic post_done;

    always_comb begin
        status = 32'd0;
        status[0] = 1'b1;
        status[1] = locked;
        status[4] = bit4_on;
        status[5] = go_writes < jit_until;
        status[7] = acks[0]; status[8] = acks[1];
        status[10] = acks[2]; status[11] = acks[3];
    end

    always @(posedge clk) begin
        if (!rst_n || clr_stats) begin
            go_bit <= 0; locked <= 0; armed <= 0; acks <= 0;
            go_cnt <= 0; lk_cnt <= 0; ack_cnt <= 0; go_writes <= 0;
            cfg2_n <= 0; late_wr <= 0; post_done <= 0; reg_rvalid <= 0;
            reg_rdata <= 0; cfg1_w <= 0; cfg2_w <= 0; cfg3_w <= 0;
            cfg2_first <= 0; cfg2_second <= 0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= (reg_addr == 3'd0) ? {31'd0, go_bit} : status;
            if (go_bit && !go_stuck) begin
                go_cnt <= go_cnt + 1;
                if (go_cnt >= go_delay) begin go_bit <= 0; armed <= 1; lk_cnt <= 0; end
            end
            if (armed && !locked && !no_lock) begin
                lk_cnt <= lk_cnt + 1;
                if (lk_cnt >= lock_delay) locked <= 1;
            end
            if (!ack_stuck) begin
                if (ack_cnt < 1000000) ack_cnt <= ack_cnt + 1;
                if (ack_cnt >= ack_delay) acks <= {cfg2_w[25], cfg2_w[23], cfg2_w[18], cfg2_w[16]};
            end
            if (done) post_done <= 1;
            if (reg_wr) begin
                if (post_done) late_wr <= late_wr + 1;
                case (reg_addr)
                    3'd0: if (reg_wdata[0]) begin
                        go_bit <= 1; go_cnt <= 0; locked <= 0; armed <= 0;
                        go_writes <= go_writes + 1;
                    end
                    3'd2: cfg1_w <= reg_wdata;
                    3'd3: begin
                        cfg2_w <= reg_wdata;
                        if (cfg2_n == 0) cfg2_first <= reg_wdata;
                        else             cfg2_second <= reg_wdata;
                        cfg2_n <= cfg2_n + 1; ack_cnt <= 0; acks <= 0;
                    end
                    3'd4: cfg3_w <= reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Bench bookkeeping
    int nchk = 0, nfail = 0, elapsed;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: act=0x%08h exp=0x%08h", req, what, act, exp);
        end
    endtask

    // Expected words, from the field rules in the requirements
    function automatic logic [31:0] dsub(input logic [4:0] d);
        return (d == 0) ? 32'd0 : 32'(d - 1);
    endfunction
    function automatic logic [3:0] band(input logic [15:0] f);
        if (f < 1000) return 4'd3;
        if (f < 1250) return 4'd4;
        if (f < 1500) return 4'd5;
        if (f < 1750) return 4'd6;
        return 4'd7;
    endfunction
    function automatic logic [31:0] e_cfg1(input logic [55:0] v);
        return 32'(v[55:48] - 8'd1) | (32'(v[47:36]) << 8) | (dsub(v[35:31]) << 20) | (dsub(v[30:26]) << 25);
    endfunction
    function automatic logic [31:0] e_cfg3(input logic [55:0] v);
        return dsub(v[25:21]) | (dsub(v[20:16]) << 5);
    endfunction
    function automatic logic [31:0] e_pre(input logic [55:0] v);
        return (32'(band(v[15:0])) << 1) | (32'd1 << 13) | (32'd1 << 20) | (32'd3 << 21);
    endfunction
    function automatic logic [31:0] e_post(input logic [55:0] v);
        logic [31:0] w;
        w = (32'(band(v[15:0])) << 1) | (32'd1 << 13) | (32'd1 << 14) | (32'd3 << 21);
        if (v[35:31] != 0) w[16] = 1'b1;
        if (v[30:26] != 0) w[18] = 1'b1;
        if (v[25:21] != 0) w[23] = 1'b1;
        if (v[20:16] != 0) w[25] = 1'b1;
        return w;
    endfunction

    // {n, m, d0, d1, d2, d3, fint_khz}
    localparam logic [55:0] VEC [7] = '{
        {8'd2,  12'd100, 5'd4,  5'd0, 5'd7,  5'd1, 16'd900},
        {8'd1,  12'd255, 5'd1,  5'd2, 5'd0,  5'd0, 16'd1100},
        {8'd5,  12'd801, 5'd31, 5'd9, 5'd3,  5'd6, 16'd1300},
        {8'd3,  12'd42,  5'd0,  5'd0, 5'd0,  5'd0, 16'd1600},
        {8'd255,12'd4095,5'd16, 5'd17,5'd18, 5'd19,16'd2000},
        {8'd7,  12'd10,  5'd2,  5'd0, 5'd0,  5'd5, 16'd1000},
        {8'd4,  12'd300, 5'd0,  5'd3, 5'd8,  5'd0, 16'd1750}
    };

    task automatic knobs_default();
        go_delay = 3; lock_delay = 40; ack_delay = 10; jit_until = 0;
        go_stuck = 0; no_lock = 0; ack_stuck = 0; bit4_on = 0;
    endtask

    task automatic run(input logic wa, input logic [55:0] v);
        @(negedge clk);
        clr_stats = 1;
        @(negedge clk);
        clr_stats = 0;
        retry_mode = wa;
        div_n = v[55:48]; div_m = v[47:36];
        div_x[0] = v[35:31]; div_x[1] = v[30:26];
        div_x[2] = v[25:21]; div_x[3] = v[20:16];
        fint_khz = v[15:0];
        start = 1;
        @(negedge clk);
        start = 0;
        elapsed = 1;
        while (!done && elapsed < 60000) begin
            @(negedge clk);
            elapsed++;
        end
    endtask

    task automatic check_finish(input string req, input logic exp_err, input logic [1:0] exp_code);
        chk(done === 1'b1, "R11", {req, " done seen"}, 32'(done), 1);
        chk(error === exp_err, req, "error flag", 32'(error), 32'(exp_err));
        chk(err_code === exp_code, req, "error code", 32'(err_code), 32'(exp_code));
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", "done is one cycle", 32'({done, busy}), 0);
        chk(err_code === exp_code, "R11", "code held", 32'(err_code), 32'(exp_code));
        repeat (5) @(negedge clk);
        chk(late_wr == 0, "R11", "writes after finish", 32'(late_wr), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R11 watchdog expired: act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        knobs_default();
        clr_stats = 0; start = 0; retry_mode = 0;
        div_n = 1; div_m = 0; div_x = '0; fint_khz = 0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1: reset state and no traffic
        chk({busy, done, error, err_code} === 5'd0, "R1", "idle outputs", 32'({busy, done, error, err_code}), 0);
        chk(go_writes == 0 && cfg2_n == 0, "R1", "no writes before start", 32'(go_writes + cfg2_n), 0);

        // Table walk in normal mode
        for (int i = 0; i < 7; i++) begin
            knobs_default();
            run(1'b0, VEC[i]);
            chk(cfg1_w === e_cfg1(VEC[i]), "R2", "first config word", cfg1_w, e_cfg1(VEC[i]));
            chk(cfg3_w === e_cfg3(VEC[i]), "R3", "third config word", cfg3_w, e_cfg3(VEC[i]));
            chk(cfg2_first === e_pre(VEC[i]), "R4", "pre-lock word", cfg2_first, e_pre(VEC[i]));
            chk(cfg2_first[4:1] === band(VEC[i][15:0]), "R5", "band field", 32'(cfg2_first[4:1]), 32'(band(VEC[i][15:0])));
            chk(cfg2_second === e_post(VEC[i]), "R9", "release word", cfg2_second, e_post(VEC[i]));
            chk(go_writes == 1, "R6", "one GO write", 32'(go_writes), 1);
            check_finish("R10", 1'b0, 2'd0);
        end

        // R7: lock arriving after the fast phase still succeeds
        knobs_default(); lock_delay = 600;
        run(1'b0, VEC[0]);
        chk(elapsed > 600, "R7", "slow lock waited", 32'(elapsed), 600);
        check_finish("R7", 1'b0, 2'd0);

        // R6/R7: no lock -> code 2 after the long limit, bypass never released (R9)
        knobs_default(); no_lock = 1;
        run(1'b0, VEC[1]);
        chk(elapsed >= LONG_TMO, "R7", "lock timeout not early", 32'(elapsed), LONG_TMO);
        chk(cfg2_n == 1, "R9", "no release on lock failure", 32'(cfg2_n), 1);
        check_finish("R6", 1'b1, 2'd2);

        // R6: GO never clears -> code 1
        knobs_default(); go_stuck = 1;
        run(1'b0, VEC[2]);
        chk(elapsed >= LONG_TMO, "R7", "GO timeout not early", 32'(elapsed), LONG_TMO);
        check_finish("R6", 1'b1, 2'd1);

        // R10: late but in-window ack succeeds, missing ack fails
        knobs_default(); ack_delay = 200;
        run(1'b0, VEC[2]);
        check_finish("R10", 1'b0, 2'd0);
        knobs_default(); ack_stuck = 1;
        run(1'b0, VEC[2]);
        check_finish("R10", 1'b1, 2'd3);

        // R8: retry mode, jitter clears on third attempt, bit 4 set throughout
        knobs_default(); jit_until = 3; bit4_on = 1;
        run(1'b1, VEC[4]);
        chk(go_writes == 3, "R8", "attempt count", 32'(go_writes), 3);
        chk(elapsed >= 3 * SETTLE, "R8", "settle per attempt", 32'(elapsed), 3 * SETTLE);
        chk(cfg2_second === e_post(VEC[4]), "R8", "release after retry lock", cfg2_second, e_post(VEC[4]));
        check_finish("R8", 1'b0, 2'd0);

        // R8: jitter never clears -> 20 attempts then code 2
        knobs_default(); jit_until = 1000;
        run(1'b1, VEC[5]);
        chk(go_writes == 20, "R8", "attempt limit", 32'(go_writes), 20);
        chk(cfg2_n == 1, "R9", "no release after retries", 32'(cfg2_n), 1);
        check_finish("R8", 1'b1, 2'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule